// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular results queue placed between instruction dispatch and the register file. Dispatch claims the slot at the tail and receives that slot's index. Execution units can finish their work in any order. Each one reports its result, together with an exception flag, against the slot index it was given. Results leave the queue only from the head, one per cycle, and only when the head slot has finished. The register file therefore sees writes in program order.

The number of slots bounds how far younger work can run ahead of an unfinished older instruction. With `DEPTH` slots, at most `DEPTH-1` younger entries can sit behind a stalled head.

A mispredicted branch, named by its slot index, trims every younger slot. An entry that reaches the head with its exception flag set does not write the register file. Instead it reports its index and empties the whole queue, so that execution can restart from that instruction.

Top module: `reorder_buf`

## Requirements
- R1: After reset the queue is empty: `alloc_ready`=1, `alloc_idx`=0, and `ret_valid`, `exc_valid` and `squash` are 0.
- R2: Each accepted allocation (`alloc_valid` and `alloc_ready` both high at a clock edge) takes the index shown on `alloc_idx`. Successive allocations get consecutive indices modulo `DEPTH`.
- R3: When `DEPTH` entries are occupied, `alloc_ready` is 0 and an allocation request has no effect. Entries still retire normally.
- R4: `ret_valid` is high only when the head entry has finished. A finished younger entry waits until every older entry has retired, and entries retire in allocation order.
- R5: While `ret_valid` is high, `ret_dest` and `ret_data` carry the head entry's destination register and result. The head advances by one at that clock edge, and an allocation may be accepted in the same cycle.
- R6: A completion whose `cmp_idx` names a slot that is not in flight is ignored.
- R7: When the head entry has finished with its exception flag set, `ret_valid` is 0, `exc_valid` is 1 and `exc_idx` is the head index. After that edge the queue is empty, and the next allocation receives the index following the faulting entry.
- R8: `mis_valid` with `mis_idx` discards every entry younger than that branch. The next allocation index becomes `mis_idx+1` modulo `DEPTH`, and the branch and older entries are kept.
- R9: `squash` is 1 in any cycle with an accepted mispredict or a retiring exception. In such a cycle `alloc_ready` is 0, and an exception takes priority over a mispredict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_dest | input | REG_W | Destination register of the dispatched instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_idx | output | IDX_W | Index of the slot that an allocation takes |
| cmp_valid | input | 1 | An execution unit reports a finished entry |
| cmp_idx | input | IDX_W | Slot being finished |
| cmp_data | input | DATA_W | Result value |
| cmp_exc | input | 1 | The finished entry faulted |
| mis_valid | input | 1 | A branch was mispredicted |
| mis_idx | input | IDX_W | Slot of the mispredicted branch |
| ret_valid | output | 1 | Register file write enable |
| ret_dest | output | REG_W | Register file write address |
| ret_data | output | DATA_W | Register file write data |
| exc_valid | output | 1 | Head entry retires as an exception |
| exc_idx | output | IDX_W | Slot of the faulting entry |
| squash | output | 1 | Younger work is being discarded this cycle |

## Verification
The embedded properties check the structural rules on every cycle:
- occupancy never exceeds `DEPTH`;
- a full queue holds its tail;
- every retirement moves the head by exactly one;
- an exception always leaves the queue empty;
- a mispredict places the tail just past the branch;
- a retirement and an exception never occur in the same cycle.

Some behaviour needs the bench's scenarios instead. Only those can show that results emerge in program order with the correct destination and value. They also show that completions to dead slots are dropped, and that stale results left in a reused slot never reach the register file. Finally, they show that the index sequence wraps correctly across many allocations.

// File: rtl/reorder_buf.sv
module reorder_buf #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [REG_W-1:0]  alloc_dest,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              cmp_exc,
  input  logic              mis_valid,
  input  logic [IDX_W-1:0]  mis_idx,
  output logic              ret_valid,
  output logic [REG_W-1:0]  ret_dest,
  output logic [DATA_W-1:0] ret_data,
  output logic              exc_valid,
  output logic [IDX_W-1:0]  exc_idx,
  output logic              squash
);

  logic [PTR_W-1:0]  head, tail, count, mis_tail;
  logic [IDX_W-1:0]  hidx, cmp_off, mis_off;
  logic [DEPTH-1:0]  done_q, excf_q;
  logic [REG_W-1:0]  dest_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic full, empty, head_done, cmp_live, alloc_fire;

  assign hidx      = head[IDX_W-1:0];
  assign count     = tail - head;
  assign full      = (count == PTR_W'(DEPTH));
  assign empty     = (count == '0);
  assign head_done = !empty && done_q[hidx];

  assign ret_valid = head_done && !excf_q[hidx];
  assign exc_valid = head_done &&  excf_q[hidx];
  assign ret_dest  = dest_q[hidx];
  assign ret_data  = data_q[hidx];
  assign exc_idx   = hidx;

  assign squash      = exc_valid || mis_valid;
  assign alloc_ready = !full && !squash;
  assign alloc_idx   = tail[IDX_W-1:0];
  assign alloc_fire  = alloc_valid && alloc_ready;

  assign cmp_off  = cmp_idx - hidx;
  assign cmp_live = cmp_valid && (PTR_W'(cmp_off) < count);
  assign mis_off  = mis_idx - hidx;
  assign mis_tail = head + PTR_W'(mis_off) + PTR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else if (exc_valid) begin
      head <= head + PTR_W'(1);
      tail <= head + PTR_W'(1);
    end else begin
      if (ret_valid) head <= head + PTR_W'(1);
      if (mis_valid)       tail <= mis_tail;
      else if (alloc_fire) tail <= tail + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      excf_q <= '0;
    end else begin
      if (cmp_live) begin
        done_q[cmp_idx] <= 1'b1;
        excf_q[cmp_idx] <= cmp_exc;
      end
      if (alloc_fire) begin
        done_q[alloc_idx] <= 1'b0;
        excf_q[alloc_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cmp_live)   data_q[cmp_idx]   <= cmp_data;
    if (alloc_fire) dest_q[alloc_idx] <= alloc_dest;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PTR_W'(DEPTH));

  a_r3_full_holds_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !squash) |=> (tail == $past(tail)));

  a_r4_head_steps_one: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> (head == $past(head) + PTR_W'(1)));

  a_r5_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(ret_valid && exc_valid));

  a_r7_exc_drains: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (count == '0));

  a_r8_mis_trims_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_valid && !exc_valid) |=> (tail == $past(mis_tail)));

endmodule

// File: tb/reorder_buf_bench.sv
module reorder_buf_bench;
  localparam int DEPTH = 4, DATA_W = 16, REG_W = 5, IDX_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 1'b0, cmp_valid = 1'b0, cmp_exc = 1'b0, mis_valid = 1'b0;
  logic [REG_W-1:0]  alloc_dest = '0;
  logic [IDX_W-1:0]  cmp_idx = '0, mis_idx = '0;
  logic [DATA_W-1:0] cmp_data = '0;
  logic alloc_ready, ret_valid, exc_valid, squash;
  logic [IDX_W-1:0]  alloc_idx, exc_idx;
  logic [REG_W-1:0]  ret_dest;
  logic [DATA_W-1:0] ret_data;
  int nchk = 0, nbad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  reorder_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) u_reorder_buf (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_dest(alloc_dest),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
    .mis_valid(mis_valid), .mis_idx(mis_idx),
    .ret_valid(ret_valid), .ret_dest(ret_dest), .ret_data(ret_data),
    .exc_valid(exc_valid), .exc_idx(exc_idx), .squash(squash));

  typedef struct packed {
    int av, ad, cv, ci, cd, ce, mv, mi;
    int e_rdy, e_aidx, e_rv, e_rd, e_data, e_exc, e_eidx, e_sq, req;
  } vec_t;

  localparam int NV = 16;
  // inputs | expected ready, alloc_idx, retire, exception, squash | requirement
  localparam vec_t VECS [NV] = '{
    '{1,1, 0,0,0,0,       0,0, 1,0, 0,0,0,      0,0,0, 2}, // R2 first slot
    '{1,2, 1,1,'h77,0,    0,0, 1,1, 0,0,0,      0,0,0, 6}, // R6 idx1 not live yet
    '{1,3, 1,1,'h22,0,    0,0, 1,2, 0,0,0,      0,0,0, 2},
    '{1,4, 0,0,0,0,       0,0, 1,3, 0,0,0,      0,0,0, 4}, // R4 younger done, head not
    '{1,5, 1,0,'h11,0,    0,0, 0,0, 0,0,0,      0,0,0, 3}, // R3 full, request dropped
    '{0,0, 0,0,0,0,       0,0, 0,0, 1,1,'h11,   0,0,0, 5}, // R5 head retires
    '{1,6, 0,0,0,0,       0,0, 1,0, 1,2,'h22,   0,0,0, 5}, // R5 retire + alloc, R6 kept 22
    '{0,0, 1,3,'h44,0,    0,0, 1,1, 0,0,0,      0,0,0, 4},
    '{0,0, 0,0,0,0,       1,3, 0,1, 0,0,0,      0,0,1, 9}, // R9 mispredict cycle
    '{1,7, 1,0,'h99,0,    0,0, 1,0, 0,0,0,      0,0,0, 8}, // R8 tail trimmed to idx0
    '{0,0, 1,2,'h33,1,    0,0, 1,1, 0,0,0,      0,0,0, 7},
    '{0,0, 0,0,0,0,       0,0, 0,1, 0,0,0,      1,2,1, 7}, // R7 exception at head
    '{1,8, 0,0,0,0,       0,0, 1,3, 0,0,0,      0,0,0, 7}, // R7 restart index
    '{0,0, 1,3,'h55,0,    0,0, 1,0, 0,0,0,      0,0,0, 7},
    '{0,0, 0,0,0,0,       0,0, 1,0, 1,8,'h55,   0,0,0, 5}, // stale 44 not used
    '{0,0, 0,0,0,0,       0,0, 1,0, 0,0,0,      0,0,0, 8}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input int av, ad, cv, ci, cd, ce, mv, mi);
    alloc_valid = 1'(av); alloc_dest = 5'(ad);
    cmp_valid = 1'(cv); cmp_idx = 2'(ci); cmp_data = 16'(cd); cmp_exc = 1'(ce);
    mis_valid = 1'(mv); mis_idx = 2'(mi);
    #2;
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    end
  endtask

  initial begin
    #(20 * 50000);
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int exp_t;
    apply(0,0,0,0,0,0,0,0);
    #5;
    // R1 reset state
    chk("R1 ready", int'(alloc_ready), 1);
    chk("R1 alloc_idx", int'(alloc_idx), 0);
    chk("R1 ret_valid", int'(ret_valid), 0);
    chk("R1 exc_valid", int'(exc_valid), 0);
    chk("R1 squash", int'(squash), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      apply(v.av, v.ad, v.cv, v.ci, v.cd, v.ce, v.mv, v.mi);
      chk($sformatf("R%0d vec%0d ready", v.req, i), int'(alloc_ready), v.e_rdy);
      chk($sformatf("R%0d vec%0d alloc_idx", v.req, i), int'(alloc_idx), v.e_aidx);
      chk($sformatf("R%0d vec%0d ret_valid", v.req, i), int'(ret_valid), v.e_rv);
      if (v.e_rv != 0) begin
        chk($sformatf("R%0d vec%0d ret_dest", v.req, i), int'(ret_dest), v.e_rd);
        chk($sformatf("R%0d vec%0d ret_data", v.req, i), int'(ret_data), v.e_data);
      end
      chk($sformatf("R%0d vec%0d exc_valid", v.req, i), int'(exc_valid), v.e_exc);
      if (v.e_exc != 0)
        chk($sformatf("R%0d vec%0d exc_idx", v.req, i), int'(exc_idx), v.e_eidx);
      chk($sformatf("R%0d vec%0d squash", v.req, i), int'(squash), v.e_sq);
      tick();
    end

    // R4: finish in reverse order, retire in allocation order
    for (int k = 0; k < 3; k++) begin
      apply(1, 10 + k, 0,0,0,0, 0,0);
      chk("R2 reverse alloc_idx", int'(alloc_idx), k);
      tick();
    end
    for (int k = 2; k >= 0; k--) begin
      apply(0,0, 1, k, 'hA0 + k, 0, 0,0);
      chk("R4 waits for head", int'(ret_valid), 0);
      tick();
    end
    for (int k = 0; k < 3; k++) begin
      apply(0,0,0,0,0,0,0,0);
      chk("R4 order valid", int'(ret_valid), 1);
      chk("R4 order dest", int'(ret_dest), 10 + k);
      chk("R5 order data", int'(ret_data), 'hA0 + k);
      tick();
    end
    apply(0,0,0,0,0,0,0,0);
    chk("R4 drained", int'(ret_valid), 0);

    // R2: index wraps across many allocations
    exp_t = 3;
    for (int k = 0; k < 6; k++) begin
      apply(1, 16 + k, 0,0,0,0, 0,0);
      chk("R2 wrap alloc_idx", int'(alloc_idx), exp_t);
      tick();
      apply(0,0, 1, exp_t, 'h100 + k, 0, 0,0);
      tick();
      apply(0,0,0,0,0,0,0,0);
      chk("R5 wrap dest", int'(ret_dest), 16 + k);
      chk("R5 wrap data", int'(ret_data), 'h100 + k);
      tick();
      exp_t = (exp_t + 1) % DEPTH;
    end

    // R1: reset from a busy state
    apply(1, 3, 0,0,0,0, 0,0);
    tick();
    apply(0,0,0,0,0,0,0,0);
    rst_n = 1'b0;
    #2;
    chk("R1 busy reset ready", int'(alloc_ready), 1);
    chk("R1 busy reset idx", int'(alloc_idx), 0);
    chk("R1 busy reset ret", int'(ret_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();

    summary();
    $finish;
  end
endmodule